// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the upstream side of a PCI-to-PCI bridge. It decides whether a request address should be claimed and passed downstream. The bridge has three forwarding apertures: an I/O window, a non-prefetchable memory window and a prefetchable memory window. The block takes the raw packed base and limit register values, their upper-extension registers and the two command enables. It expands them into full-width inclusive address bounds.

Each request carries an address and a space flag. The block compares the address against the windows that belong to that space. One clock later it reports whether the request is forwarded and which window claimed it. The block has no configuration storage of its own: register values are wired in from the configuration space that owns them.

Top module: `bridge_window_decoder`

## Requirements
- R1: A request presented with `req_valid` high is answered on `out_valid`, `fwd_hit` and `fwd_win` exactly one clock later. A cycle with `req_valid` low gives `out_valid` low and `fwd_hit` low one clock later.
- R2: While `rst_n` is low at a clock edge, `out_valid` and `fwd_hit` become 0 and `fwd_win` becomes 0.
- R3: I/O window bounds:
  - The I/O base is `{U, io_base_reg[7:4], 12'h000}`.
  - The I/O limit is `{U, io_limit_reg[7:4], 12'hFFF}`.
  - For each bound, U is that bound's 16-bit upper register when the low nibble of its 8-bit register equals 1. Otherwise U is zero.
- R4: An I/O request (`req_is_io`=1) is checked only against the I/O window, using `req_addr[31:0]`; bits [63:32] have no effect. A memory request is never claimed by the I/O window.
- R5: Memory window bounds:
  - The base is `{32'h0, mem_base_reg[15:4], 20'h00000}`.
  - The limit is `{32'h0, mem_limit_reg[15:4], 20'hFFFFF}`.
  - The comparison uses all 64 address bits, so a memory address with any of bits [63:32] set misses this window.
- R6: Prefetchable window bounds:
  - The base is `{V, pf_base_reg[15:4], 20'h00000}`.
  - The limit is `{V, pf_limit_reg[15:4], 20'hFFFFF}`.
  - For each bound, V is that bound's 32-bit upper register when the low nibble of its 16-bit register equals 1. Otherwise V is zero.
- R7: A window whose limit is below its base never claims any address.
- R8: The I/O window claims requests only while `cmd_io_en` is 1. Both memory windows claim requests only while `cmd_mem_en` is 1.
- R9: `fwd_win` encodes 0 = none, 1 = I/O, 2 = memory, 3 = prefetchable. `fwd_hit` is 1 exactly when `fwd_win` is non-zero. If both memory windows contain the address, the prefetchable window (3) is reported.
- R10: Window bounds are inclusive. An address equal to the base or to the limit is claimed; an address one below the base or one above the limit is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O space request, 0 = memory space request |
| req_addr | input | 64 | Request address |
| cmd_io_en | input | 1 | Command I/O space enable |
| cmd_mem_en | input | 1 | Command memory space enable |
| io_base_reg | input | 8 | Packed I/O base (bits [7:4] address, [3:0] width type) |
| io_limit_reg | input | 8 | Packed I/O limit (bits [7:4] address, [3:0] width type) |
| io_base_upper | input | 16 | I/O base bits [31:16] |
| io_limit_upper | input | 16 | I/O limit bits [31:16] |
| mem_base_reg | input | 16 | Packed memory base (bits [15:4] address) |
| mem_limit_reg | input | 16 | Packed memory limit (bits [15:4] address) |
| pf_base_reg | input | 16 | Packed prefetchable base (bits [15:4] address, [3:0] width type) |
| pf_limit_reg | input | 16 | Packed prefetchable limit (bits [15:4] address, [3:0] width type) |
| pf_base_upper | input | 32 | Prefetchable base bits [63:32] |
| pf_limit_upper | input | 32 | Prefetchable limit bits [63:32] |
| out_valid | output | 1 | Result valid, one cycle after the request |
| fwd_hit | output | 1 | Request is forwarded downstream |
| fwd_win | output | 2 | Claiming window code |

## Verification
The assertions assume that `req_valid` is held low while reset is asserted. They also assume that the configuration and enable inputs are stable in the cycle a request is sampled, because the gating checks look back one cycle at those inputs. The stimulus meets both assumptions. Every input is changed on the falling edge, so each request is sampled with the configuration it was issued under. The request is held idle until reset has been released. The window registers are reprogrammed only between requests, never in the middle of a sampled cycle.

// File: rtl/bwd_pkg.sv
`timescale 1ns/1ps
// Package: shared window codes and widths for the bridge window decoder.
// Assumes: window code values are visible at the top-level port (fixed encoding).
package bwd_pkg;
    localparam int IO_REG_W   = 8;
    localparam int MEM_REG_W  = 16;
    localparam int IO_UP_W    = 16;
    localparam int PF_UP_W    = 32;
    localparam int IO_GRAN    = 12;
    localparam int MEM_GRAN   = 20;
    localparam logic [3:0] WIDE_TYPE = 4'h1;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_IO   = 2'd1,
        WIN_MEM  = 2'd2,
        WIN_PREF = 2'd3
    } win_e;
endpackage

// File: rtl/bwd_io_bounds.sv
`timescale 1ns/1ps
// Module: bwd_io_bounds
// Expands packed I/O base/limit registers into full inclusive 32-bit bounds.
// Assumes: low nibble of each packed register is its width type; value 1 selects
// the 16-bit upper register, any other value zeroes the upper half.
module bwd_io_bounds
    import bwd_pkg::*;
(
    input  logic [IO_REG_W-1:0]          base_lo,
    input  logic [IO_REG_W-1:0]          lim_lo,
    input  logic [IO_UP_W-1:0]           base_hi,
    input  logic [IO_UP_W-1:0]           lim_hi,
    output logic [IO_UP_W+IO_GRAN+3:0]   base,
    output logic [IO_UP_W+IO_GRAN+3:0]   limit
);
    localparam int NIB = IO_REG_W - 4;

    logic base_wide;
    logic lim_wide;

    // Decode each register's own width type.
    always_comb begin
        base_wide = (base_lo[3:0] == WIDE_TYPE);
        lim_wide  = (lim_lo[3:0]  == WIDE_TYPE);
    end

    // Assemble bounds: base padded with zeros, limit padded with ones.
    always_comb begin
        base  = {(base_wide ? base_hi : {IO_UP_W{1'b0}}),
                 base_lo[IO_REG_W-1 -: NIB], {IO_GRAN{1'b0}}};
        limit = {(lim_wide ? lim_hi : {IO_UP_W{1'b0}}),
                 lim_lo[IO_REG_W-1 -: NIB], {IO_GRAN{1'b1}}};
    end
endmodule

// File: rtl/bwd_mem_bounds.sv
`timescale 1ns/1ps
// Module: bwd_mem_bounds
// Expands packed memory base/limit registers into full inclusive 64-bit bounds.
// HAS_UPPER=1 builds the prefetchable variant, whose upper 32 bits come from the
// upper registers when the width type nibble equals 1; HAS_UPPER=0 always zeroes them.
// Assumes: register bits [15:4] map to address bits [31:20].
module bwd_mem_bounds
    import bwd_pkg::*;
#(
    parameter bit HAS_UPPER = 1'b0
)(
    input  logic [MEM_REG_W-1:0]          base_lo,
    input  logic [MEM_REG_W-1:0]          lim_lo,
    input  logic [PF_UP_W-1:0]            base_hi,
    input  logic [PF_UP_W-1:0]            lim_hi,
    output logic [PF_UP_W+MEM_GRAN+11:0]  base,
    output logic [PF_UP_W+MEM_GRAN+11:0]  limit
);
    localparam int FLD = MEM_REG_W - 4;

    logic base_wide;
    logic lim_wide;

    // Upper extension is honoured only in the prefetchable variant.
    always_comb begin
        base_wide = HAS_UPPER && (base_lo[3:0] == WIDE_TYPE);
        lim_wide  = HAS_UPPER && (lim_lo[3:0]  == WIDE_TYPE);
    end

    // Assemble 64-bit bounds with 1 MB granularity.
    always_comb begin
        base  = {(base_wide ? base_hi : {PF_UP_W{1'b0}}),
                 base_lo[MEM_REG_W-1 -: FLD], {MEM_GRAN{1'b0}}};
        limit = {(lim_wide ? lim_hi : {PF_UP_W{1'b0}}),
                 lim_lo[MEM_REG_W-1 -: FLD], {MEM_GRAN{1'b1}}};
    end
endmodule

// File: rtl/bwd_range_cmp.sv
`timescale 1ns/1ps
// Module: bwd_range_cmp
// Inclusive range test: hit when enabled and base <= addr <= limit.
// Assumes: an inverted window (limit < base) must never hit; the explicit
// ordering term keeps that true even if the two address compares are retimed.
module bwd_range_cmp #(
    parameter int W = 32
)(
    input  logic         en,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] addr,
    output logic         hit
);
    logic ordered;
    logic above;
    logic below;

    // Unsigned magnitude compares at full width.
    always_comb begin
        ordered = (limit >= base);
        above   = (addr  >= base);
        below   = (addr  <= limit);
        hit     = en && ordered && above && below;
    end
endmodule

// File: rtl/bridge_window_decoder.sv
`timescale 1ns/1ps
// Module: bridge_window_decoder
// Decides whether an upstream request falls into the bridge's I/O, memory or
// prefetchable window and registers the verdict with one cycle of latency.
// Assumes: configuration inputs are stable when a request is sampled and
// req_valid is low during reset. Prefetchable wins over memory on overlap.
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int IO_ADDR_W = 32
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_is_io,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  cmd_io_en,
    input  logic                  cmd_mem_en,
    input  logic [IO_REG_W-1:0]   io_base_reg,
    input  logic [IO_REG_W-1:0]   io_limit_reg,
    input  logic [IO_UP_W-1:0]    io_base_upper,
    input  logic [IO_UP_W-1:0]    io_limit_upper,
    input  logic [MEM_REG_W-1:0]  mem_base_reg,
    input  logic [MEM_REG_W-1:0]  mem_limit_reg,
    input  logic [MEM_REG_W-1:0]  pf_base_reg,
    input  logic [MEM_REG_W-1:0]  pf_limit_reg,
    input  logic [PF_UP_W-1:0]    pf_base_upper,
    input  logic [PF_UP_W-1:0]    pf_limit_upper,
    output logic                  out_valid,
    output logic                  fwd_hit,
    output logic [1:0]            fwd_win
);
    localparam int NWIN = 2;

    logic [IO_ADDR_W-1:0] io_base, io_limit;
    logic [ADDR_W-1:0]    mw_base [NWIN];
    logic [ADDR_W-1:0]    mw_limit[NWIN];
    logic [NWIN-1:0]      mw_hit;
    logic                 io_hit;
    logic                 io_en, mem_en;
    win_e                 win_c;

    // Per-space enables from the command bits and request type.
    always_comb begin
        io_en  = cmd_io_en  &&  req_is_io;
        mem_en = cmd_mem_en && !req_is_io;
    end

    bwd_io_bounds u_io_bounds (
        .base_lo (io_base_reg),
        .lim_lo  (io_limit_reg),
        .base_hi (io_base_upper),
        .lim_hi  (io_limit_upper),
        .base    (io_base),
        .limit   (io_limit)
    );

    bwd_range_cmp #(.W(IO_ADDR_W)) u_io_cmp (
        .en    (io_en),
        .base  (io_base),
        .limit (io_limit),
        .addr  (req_addr[IO_ADDR_W-1:0]),
        .hit   (io_hit)
    );

    // Index 0: non-prefetchable memory, index 1: prefetchable memory.
    for (genvar g = 0; g < NWIN; g++) begin : g_mem
        bwd_mem_bounds #(.HAS_UPPER(g == 1)) u_bounds (
            .base_lo (g == 1 ? pf_base_reg    : mem_base_reg),
            .lim_lo  (g == 1 ? pf_limit_reg   : mem_limit_reg),
            .base_hi (g == 1 ? pf_base_upper  : {PF_UP_W{1'b0}}),
            .lim_hi  (g == 1 ? pf_limit_upper : {PF_UP_W{1'b0}}),
            .base    (mw_base[g]),
            .limit   (mw_limit[g])
        );
        bwd_range_cmp #(.W(ADDR_W)) u_cmp (
            .en    (mem_en),
            .base  (mw_base[g]),
            .limit (mw_limit[g]),
            .addr  (req_addr),
            .hit   (mw_hit[g])
        );
    end

    // Priority select: prefetchable over memory; I/O is exclusive by space.
    always_comb begin
        if (mw_hit[1])      win_c = WIN_PREF;
        else if (mw_hit[0]) win_c = WIN_MEM;
        else if (io_hit)    win_c = WIN_IO;
        else                win_c = WIN_NONE;
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fwd_hit   <= 1'b0;
            fwd_win   <= WIN_NONE;
        end else begin
            out_valid <= req_valid;
            fwd_hit   <= req_valid && (win_c != WIN_NONE);
            fwd_win   <= req_valid ? win_c : WIN_NONE;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !fwd_hit));
    assert_io_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_win == WIN_IO) |-> $past(cmd_io_en && req_is_io));
    assert_mem_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_win == WIN_MEM || fwd_win == WIN_PREF) |-> $past(cmd_mem_en && !req_is_io));
    assert_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_win == WIN_MEM) |-> $past(mem_limit_reg[15:4] >= mem_base_reg[15:4]));
    assert_no_stray_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (fwd_win == WIN_NONE));
endmodule

// File: tb/bridge_window_decoder_tb.sv
`timescale 1ns/1ps
module bridge_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic        cmd_io_en = 1'b0, cmd_mem_en = 1'b0;
    logic [7:0]  io_base_reg = '0, io_limit_reg = '0;
    logic [15:0] io_base_upper = '0, io_limit_upper = '0;
    logic [15:0] mem_base_reg = '0, mem_limit_reg = '0, pf_base_reg = '0, pf_limit_reg = '0;
    logic [31:0] pf_base_upper = '0, pf_limit_upper = '0;
    logic        out_valid, fwd_hit;
    logic [1:0]  fwd_win;

    int total = 0, bad = 0;

    typedef struct { logic [2:0] exp; string tag; } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    bridge_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_upper(io_base_upper), .io_limit_upper(io_limit_upper),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_upper(pf_base_upper), .pf_limit_upper(pf_limit_upper),
        .out_valid(out_valid), .fwd_hit(fwd_hit), .fwd_win(fwd_win)
    );

    // Reference model written from the requirement text: returns {hit, win}.
    function automatic logic [2:0] model(input logic is_io, input logic [63:0] a);
        logic [31:0] iob, iol;
        logic [63:0] mb, ml, pb, pl;
        logic io_h, m_h, p_h;
        iob = {(io_base_reg[3:0] == 4'h1) ? io_base_upper : 16'h0, io_base_reg[7:4], 12'h000};
        iol = {(io_limit_reg[3:0] == 4'h1) ? io_limit_upper : 16'h0, io_limit_reg[7:4], 12'hFFF};
        mb  = {32'h0, mem_base_reg[15:4], 20'h00000};
        ml  = {32'h0, mem_limit_reg[15:4], 20'hFFFFF};
        pb  = {(pf_base_reg[3:0] == 4'h1) ? pf_base_upper : 32'h0, pf_base_reg[15:4], 20'h00000};
        pl  = {(pf_limit_reg[3:0] == 4'h1) ? pf_limit_upper : 32'h0, pf_limit_reg[15:4], 20'hFFFFF};
        io_h = is_io && cmd_io_en && (iol >= iob) && (a[31:0] >= iob) && (a[31:0] <= iol);
        m_h  = !is_io && cmd_mem_en && (ml >= mb) && (a >= mb) && (a <= ml);
        p_h  = !is_io && cmd_mem_en && (pl >= pb) && (a >= pb) && (a <= pl);
        if (p_h)       return 3'b111;
        else if (m_h)  return 3'b110;
        else if (io_h) return 3'b101;
        else           return 3'b000;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one request per cycle, expected result pushed to the scoreboard.
    task automatic send(input logic is_io, input logic [63:0] a, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_is_io = is_io;
        req_addr  = a;
        it.exp = model(is_io, a);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pop one expected item per valid result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", {61'h0, fwd_hit, fwd_win}, 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({fwd_hit, fwd_win} == it.exp, it.tag, {61'h0, fwd_hit, fwd_win}, {61'h0, it.exp});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1 watchdog expired", 64'h0, 64'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !fwd_hit && fwd_win == 2'd0, "R2 reset outputs",
              {61'h0, out_valid, fwd_win}, 64'h0);
        rst_n = 1'b1;
        idle(1);
        check(!out_valid && !fwd_hit, "R1 idle gives no result", {62'h0, out_valid, fwd_hit}, 64'h0);

        // I/O window, 32-bit type: 0x0001_2000 .. 0x0001_3FFF.
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
        io_base_reg = 8'h21; io_limit_reg = 8'h31;
        io_base_upper = 16'h0001; io_limit_upper = 16'h0001;
        send(1'b1, 64'h0000_0000_0001_2000, "R10 io base edge");
        send(1'b1, 64'h0000_0000_0001_3FFF, "R3 io limit padded");
        send(1'b1, 64'h0000_0000_0001_1FFF, "R10 io below base");
        send(1'b1, 64'h0000_0000_0001_4000, "R10 io above limit");
        send(1'b1, 64'hDEAD_BEEF_0001_2800, "R4 io ignores upper addr bits");
        send(1'b0, 64'h0000_0000_0001_2800, "R4 memory req not io window");
        idle(2);
        // 16-bit type: upper registers must be ignored.
        io_base_reg = 8'h20; io_limit_reg = 8'h30;
        send(1'b1, 64'h0000_0000_0000_2000, "R3 io 16-bit ignores upper");
        send(1'b1, 64'h0000_0000_0001_2000, "R3 io 16-bit upper addr misses");
        idle(2);
        cmd_io_en = 1'b0;
        send(1'b1, 64'h0000_0000_0000_2000, "R8 io disabled");
        idle(2);

        // Memory window 0x1230_0000 .. 0x124F_FFFF.
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        send(1'b0, 64'h0000_0000_1230_0000, "R10 mem base edge");
        send(1'b0, 64'h0000_0000_124F_FFFF, "R5 mem limit padded");
        send(1'b0, 64'h0000_0000_122F_FFFF, "R10 mem below base");
        send(1'b0, 64'h0000_0000_1250_0000, "R10 mem above limit");
        send(1'b0, 64'h0000_0001_1240_0000, "R5 mem upper bits miss");
        send(1'b1, 64'h0000_0000_1240_0000, "R4 io req not mem window");
        idle(2);

        // Prefetchable 64-bit window 0x2_4000_0000 .. 0x2_410F_FFFF.
        pf_base_reg = 16'h4001; pf_limit_reg = 16'h4101;
        pf_base_upper = 32'h2; pf_limit_upper = 32'h2;
        send(1'b0, 64'h0000_0002_4000_0000, "R6 pref 64-bit base");
        send(1'b0, 64'h0000_0002_410F_FFFF, "R6 pref 64-bit limit");
        send(1'b0, 64'h0000_0000_4000_0000, "R6 pref needs upper bits");
        idle(2);
        pf_base_reg = 16'h4000; pf_limit_reg = 16'h4100;
        send(1'b0, 64'h0000_0000_4080_0000, "R6 pref 32-bit ignores upper");
        send(1'b0, 64'h0000_0002_4080_0000, "R6 pref 32-bit upper addr misses");
        idle(2);

        // Overlap: pref covers the memory window.
        pf_base_reg = 16'h1000; pf_limit_reg = 16'h1FF0;
        send(1'b0, 64'h0000_0000_1234_5678, "R9 pref wins overlap");
        send(1'b0, 64'h0000_0000_1000_0000, "R9 pref only");
        idle(2);

        // Inverted windows.
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
        pf_base_reg = 16'h3000; pf_limit_reg = 16'h2FF0;
        send(1'b0, 64'h0000_0000_1800_0000, "R7 mem inverted");
        send(1'b0, 64'h0000_0000_2000_0000, "R7 mem inverted at base");
        send(1'b0, 64'h0000_0000_2FF0_0000, "R7 pref inverted");
        idle(2);
        cmd_io_en = 1'b1;
        io_base_reg = 8'h50; io_limit_reg = 8'h40;
        send(1'b1, 64'h0000_0000_0000_4800, "R7 io inverted");
        idle(2);

        // Memory enable off.
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        cmd_mem_en = 1'b0;
        send(1'b0, 64'h0000_0000_1230_0000, "R8 mem disabled");
        idle(3);
        check(sb.size() == 0, "R1 all results returned", sb.size(), 64'h0);

        // Synchronous reset clears a pending result.
        cmd_mem_en = 1'b1;
        send(1'b0, 64'h0000_0000_1230_0000, "R2 pre-reset request");
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        @(negedge clk);
        check(!out_valid && !fwd_hit && fwd_win == 2'd0, "R2 reset clears result",
              {61'h0, out_valid, fwd_win}, 64'h0);
        rst_n = 1'b1;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule